// File: doc/BRIEF.md
# Register DMA Command Executor

This block walks a list of 32-bit command words held in a word-addressed memory and turns them into register writes on a target write bus. Software places the list in memory. It then pulses `start` with the list's first word address and its length in words. The executor fetches words one at a time over a request/valid handshake. It decodes each header and then consumes that command's payload, presenting one write at a time to the target.

Every list opens with a destination-select command that loads a mask of target sub-blocks. That mask travels with every later write. Four write commands follow:

- a single write;
- an indexed burst, where every word goes to one register;
- an auto-increment burst;
- a table burst, whose offset either holds or cycles through a short window, so that a small group of registers is refilled many times from one long payload.

The executor raises `done` when the word budget runs out exactly at a command boundary. It raises a sticky `err` and stops at once on any malformed stream.

Top module: `regdma_exec`

## Requirements
- R1: Out of reset `busy`, `done`, `err`, `mem_req` and `wr_stb` are all low.
- R2: Words are fetched from `base_addr`, `base_addr+1`, ... in order, one per cycle with `mem_req` and `mem_vld` both high. The request address is held while `mem_vld` is low. `list_len` words are consumed in total. When the budget is exhausted at a header position, `done` rises and `err` stays low. A `list_len` of 0 sets `done` with no fetch. `done` and `err` are never high together, and both are cleared by the next accepted `start`.
- R3: A header equal to 32'h180AC060 is a destination-select command. The next word's bits 4:0 and 21:17 are kept, and all other bits are cleared. The result drives `wr_sel` on every later write.
- R4: For headers other than select, the opcode is header bits 30:28, and bits 19:0 are a byte offset. Opcode 3'b001 writes the following word once at that offset.
- R5: Opcode 3'b100 reads a count from bits 13:0 of the next word. The k-th payload word (k from 0) goes to offset + 4k, modulo 2^20.
- R6: Opcode 3'b011 reads a count the same way, and every payload word goes to the header offset.
- R7: Opcode 3'b101 reads a control word with count in bits 13:0, wrap length W in bits 22:19 and a hold flag in bit 31. With the flag clear, word k goes to offset + 4·(k mod W). With the flag set, every word goes to the header offset.
- R8: A count of zero produces no write, and the next word is taken as a header.
- R9: `wr_stb` stays high with `wr_sel`, `wr_off` and `wr_data` stable until `wr_rdy` is high. Each cycle with both high is exactly one write.
- R10: A header opcode outside {001, 011, 100, 101} sets `err`. It also stops all fetching and writing, with `busy` low. `err` stays set until the next `start`.
- R11: A write header seen before any select command, or a second select command in one list, sets `err`.
- R12: A write header whose offset bits 1:0 are not zero sets `err`. So does a table burst with the hold flag clear and W below 2.
- R13: If the word budget runs out inside a command (select mask, count word or payload), `err` is set after the writes already completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a list (accepted only when idle) |
| base_addr | input | ADDR_W | Word address of the first list word |
| list_len | input | 14 | Number of words in the list |
| busy | output | 1 | List in progress |
| done | output | 1 | Last list finished cleanly (sticky) |
| err | output | 1 | Last list stopped on a fault (sticky) |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | ADDR_W | Word address being fetched |
| mem_vld | input | 1 | Fetched word is valid this cycle |
| mem_data | input | 32 | Fetched word |
| wr_stb | output | 1 | Register write pending |
| wr_sel | output | 22 | Destination-select mask for the write |
| wr_off | output | 20 | Byte offset of the write |
| wr_data | output | 32 | Write data |
| wr_rdy | input | 1 | Target accepts the write |

## Verification
The assertions take two things for granted. `mem_vld` is meaningful only while `mem_req` is high. `start` is pulsed only while the block is idle, so the fetch pointer is never reloaded in the middle of a list. The bench derives `mem_vld` and `mem_data` from the current request address on every falling edge, with a pseudo-random stall pattern, and it raises `start` only after `busy` has dropped. The target's `wr_rdy` is stalled pseudo-randomly as well, so the hold rules of both handshakes are exercised on every list.

// File: rtl/regdma_pkg.sv
package regdma_pkg;

  localparam int OFF_W = 20;
  localparam int CNT_W = 14;
  localparam int SEL_W = 22;

  localparam logic [31:0]      SEL_HDR  = 32'h180A_C060;
  localparam logic [SEL_W-1:0] SEL_KEEP = 22'h3E_001F;

  typedef enum logic [2:0] {
    OP_SINGLE = 3'b001,
    OP_INDEX  = 3'b011,
    OP_AUTO   = 3'b100,
    OP_BLOCK  = 3'b101
  } op_e;

  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_INC  = 2'd1,
    AM_WRAP = 2'd2
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_SEL, S_CNT, S_DATA, S_WR
  } st_e;

  function automatic logic op_known(input logic [2:0] op);
    return (op == OP_SINGLE) || (op == OP_INDEX) ||
           (op == OP_AUTO)   || (op == OP_BLOCK);
  endfunction

  function automatic logic [CNT_W-1:0] step_idx(input logic [CNT_W-1:0] idx,
                                                input amode_e m,
                                                input logic [3:0] wrap);
    logic [CNT_W-1:0] nxt;
    nxt = idx + 1'b1;
    case (m)
      AM_INC:  return nxt;
      AM_WRAP: return (nxt == {{(CNT_W-4){1'b0}}, wrap}) ? '0 : nxt;
      default: return idx;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] word_off(input logic [OFF_W-1:0] base,
                                                input logic [CNT_W-1:0] idx);
    return base + {{(OFF_W-CNT_W-2){1'b0}}, idx, 2'b00};
  endfunction

endpackage

// File: rtl/regdma_fetch.sv
module regdma_fetch #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              take,
  output logic [ADDR_W-1:0] addr,
  output logic              empty
);
  logic [ADDR_W-1:0] ptr_q;
  logic [LEN_W-1:0]  rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      ptr_q <= base;
      rem_q <= len;
    end else if (take) begin
      ptr_q <= ptr_q + 1'b1;
      rem_q <= rem_q - 1'b1;
    end
  end

  assign addr  = ptr_q;
  assign empty = (rem_q == '0);
endmodule

// File: rtl/regdma_offgen.sv
module regdma_offgen
  import regdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] start_off,
  input  amode_e           mode,
  input  logic [3:0]       wrap,
  input  logic             step,
  output logic [OFF_W-1:0] off
);
  logic [OFF_W-1:0] base_q;
  logic [CNT_W-1:0] idx_q;
  amode_e           mode_q;
  logic [3:0]       wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
      mode_q <= AM_HOLD;
      wrap_q <= '0;
    end else if (load) begin
      base_q <= start_off;
      idx_q  <= '0;
      mode_q <= mode;
      wrap_q <= wrap;
    end else if (step) begin
      idx_q  <= step_idx(idx_q, mode_q, wrap_q);
    end
  end

  assign off = word_off(base_q, idx_q);
endmodule

// File: rtl/regdma_exec.sv
module regdma_exec
  import regdma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [13:0]       list_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_vld,
  input  logic [31:0]       mem_data,
  output logic              wr_stb,
  output logic [21:0]       wr_sel,
  output logic [19:0]       wr_off,
  output logic [31:0]       wr_data,
  input  logic              wr_rdy
);
  st_e              st;
  logic             have_sel;
  logic [SEL_W-1:0] sel_q;
  op_e              op_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      data_q;
  logic             done_q, err_q;

  // named events
  logic             f_load, f_empty, fetch_st, mem_take, starved, wr_fire;
  logic             hdr_is_sel, hdr_fault, cnt_fault;
  logic [2:0]       hdr_op;
  logic [OFF_W-1:0] hdr_off;
  logic             og_load;
  logic [OFF_W-1:0] og_start;
  amode_e           og_mode;

  assign f_load   = (st == S_IDLE) && start;
  assign fetch_st = (st == S_HDR) || (st == S_SEL) || (st == S_CNT) || (st == S_DATA);
  assign mem_req  = fetch_st && !f_empty;
  assign mem_take = mem_req && mem_vld;
  assign starved  = fetch_st && f_empty;
  assign wr_stb   = (st == S_WR);
  assign wr_fire  = wr_stb && wr_rdy;

  assign hdr_is_sel = (mem_data == SEL_HDR);
  assign hdr_op     = mem_data[30:28];
  assign hdr_off    = mem_data[19:0];
  assign hdr_fault  = hdr_is_sel ? have_sel
                    : (!have_sel || !op_known(hdr_op) || (hdr_off[1:0] != 2'b00));
  assign cnt_fault  = (op_q == OP_BLOCK) && !mem_data[31] && (mem_data[22:19] < 4'd2);

  assign og_load  = ((st == S_HDR) && mem_take && !hdr_fault && !hdr_is_sel &&
                     (hdr_op == OP_SINGLE)) ||
                    ((st == S_CNT) && mem_take && !cnt_fault);
  assign og_start = (st == S_HDR) ? hdr_off : off_q;

  always_comb begin
    og_mode = AM_HOLD;
    if (st == S_CNT) begin
      case (op_q)
        OP_AUTO:  og_mode = AM_INC;
        OP_BLOCK: og_mode = mem_data[31] ? AM_HOLD : AM_WRAP;
        default:  og_mode = AM_HOLD;
      endcase
    end
  end

  regdma_fetch #(.ADDR_W(ADDR_W), .LEN_W(CNT_W)) u_fetch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (f_load),
    .base  (base_addr),
    .len   (list_len),
    .take  (mem_take),
    .addr  (mem_addr),
    .empty (f_empty)
  );

  regdma_offgen u_offgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (og_load),
    .start_off (og_start),
    .mode      (og_mode),
    .wrap      (mem_data[22:19]),
    .step      (wr_fire),
    .off       (wr_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      have_sel <= 1'b0;
      sel_q    <= '0;
      op_q     <= OP_SINGLE;
      off_q    <= '0;
      cnt_q    <= '0;
      data_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done_q   <= (list_len == '0);
          err_q    <= 1'b0;
          have_sel <= 1'b0;
          sel_q    <= '0;
          if (list_len != '0) st <= S_HDR;
        end
        S_HDR: if (starved) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else if (mem_take) begin
          if (hdr_fault) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (hdr_is_sel) begin
            st <= S_SEL;
          end else begin
            op_q  <= op_e'(hdr_op);
            off_q <= hdr_off;
            if (hdr_op == OP_SINGLE) begin
              cnt_q <= CNT_W'(1);
              st    <= S_DATA;
            end else begin
              st    <= S_CNT;
            end
          end
        end
        S_SEL: if (starved) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end else if (mem_take) begin
          sel_q    <= mem_data[SEL_W-1:0] & SEL_KEEP;
          have_sel <= 1'b1;
          st       <= S_HDR;
        end
        S_CNT: if (starved) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end else if (mem_take) begin
          if (cnt_fault) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else begin
            cnt_q <= mem_data[CNT_W-1:0];
            st    <= (mem_data[CNT_W-1:0] == '0) ? S_HDR : S_DATA;
          end
        end
        S_DATA: if (starved) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end else if (mem_take) begin
          data_q <= mem_data;
          st     <= S_WR;
        end
        S_WR: if (wr_fire) begin
          cnt_q <= cnt_q - 1'b1;
          st    <= (cnt_q == CNT_W'(1)) ? S_HDR : S_DATA;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign wr_sel  = sel_q;
  assign wr_data = data_q;
endmodule

// File: rtl/regdma_exec_chk.sv
module regdma_exec_chk
  import regdma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_vld,
  input logic              wr_stb,
  input logic [21:0]       wr_sel,
  input logic [19:0]       wr_off,
  input logic [31:0]       wr_data,
  input logic              wr_rdy
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !wr_rdy |=> wr_stb && $stable(wr_off) && $stable(wr_data) && $stable(wr_sel)); // R9

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_vld |=> mem_req && $stable(mem_addr)); // R2

  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_vld |=> !mem_req || (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R2

  AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_stb && !mem_req); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err); // R10

  AST_OFF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_off[1:0] == 2'b00); // R12

  AST_SEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_sel & ~SEL_KEEP) == '0); // R3
endmodule

bind regdma_exec regdma_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_vld  (mem_vld),
  .wr_stb   (wr_stb),
  .wr_sel   (wr_sel),
  .wr_off   (wr_off),
  .wr_data  (wr_data),
  .wr_rdy   (wr_rdy)
);

// File: tb/regdma_exec_tb.sv
module regdma_exec_tb;
  localparam int ADDR_W = 16;
  localparam logic [15:0] BASE = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] base_addr = BASE;
  logic [13:0] list_len = '0;
  logic busy, done, err, mem_req, wr_stb;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_vld = 1'b0;
  logic [31:0] mem_data = '0;
  logic [21:0] wr_sel;
  logic [19:0] wr_off;
  logic [31:0] wr_data;
  logic wr_rdy = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  regdma_exec #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .list_len(list_len), .busy(busy), .done(done), .err(err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_vld(mem_vld),
    .mem_data(mem_data), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_off(wr_off), .wr_data(wr_data), .wr_rdy(wr_rdy)
  );

  logic [31:0] mem [0:255];
  logic [19:0] exp_off [0:255];
  logic [31:0] exp_dat [0:255];
  logic [21:0] exp_sel [0:255];
  logic [19:0] got_off [0:255];
  logic [31:0] got_dat [0:255];
  logic [21:0] got_sel [0:255];
  int nexp, ngot, wp, nchk, nfail, cyc;
  logic [21:0] cur_sel;
  logic [15:0] lfsr = 16'hACE1;

  // memory responder, target model and write monitor
  always @(negedge clk) begin
    logic vld_n, rdy_n;
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    vld_n  = mem_req && (lfsr[0] | lfsr[3]);
    rdy_n  = rst_n && (lfsr[1] | lfsr[6]);
    mem_vld  <= vld_n;
    mem_data <= mem[mem_addr[7:0]];
    wr_rdy   <= rdy_n;
    if (wr_stb && rdy_n && ngot < 256) begin
      got_off[ngot] = wr_off;
      got_dat[ngot] = wr_data;
      got_sel[ngot] = wr_sel;
      ngot++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic clear_list();
    wp = 0; nexp = 0; cur_sel = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
  endtask

  task automatic put(input logic [31:0] w);
    mem[BASE[7:0] + wp[7:0]] = w;
    wp++;
  endtask

  task automatic expect_wr(input int off, input logic [31:0] d);
    exp_off[nexp] = off[19:0];
    exp_dat[nexp] = d;
    exp_sel[nexp] = cur_sel;
    nexp++;
  endtask

  function automatic logic [31:0] pay(input int k);
    return 32'hD00D_0000 + 32'(k * 7919);
  endfunction

  task automatic add_sel(input logic [31:0] mask);
    put(32'h180A_C060);
    put(mask);
    cur_sel = {mask[21:17], 12'b0, mask[4:0]};
  endtask

  task automatic add_single(input int off, input logic [31:0] d);
    put(32'h1000_0000 | 32'(off));
    put(d);
    expect_wr(off, d);
  endtask

  task automatic add_auto(input int off, input int cnt);
    put(32'h4000_0000 | 32'(off));
    put(32'(cnt));
    for (int k = 0; k < cnt; k++) begin
      put(pay(wp));
      expect_wr(off + 4 * k, pay(wp - 1));
    end
  endtask

  task automatic add_index(input int off, input int cnt);
    put(32'h3000_0000 | 32'(off));
    put(32'(cnt));
    for (int k = 0; k < cnt; k++) begin
      put(pay(wp));
      expect_wr(off, pay(wp - 1));
    end
  endtask

  task automatic add_block(input int off, input bit hold, input int wrap, input int cnt);
    put(32'h5000_0000 | 32'(off));
    put({hold, 8'b0, wrap[3:0], 5'b0, cnt[13:0]});
    for (int k = 0; k < cnt; k++) begin
      put(pay(wp));
      expect_wr(hold ? off : off + 4 * (k % wrap), pay(wp - 1));
    end
  endtask

  task automatic run_list(input int len, input bit exp_err, input string tag);
    int t;
    ngot = 0;
    list_len = len[13:0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    check(err == exp_err, tag, "err flag", longint'(err), longint'(exp_err));
    check(done == !exp_err, tag, "done flag", longint'(done), longint'(!exp_err));
    check(ngot == nexp, exp_err ? tag : "R9", "write count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++) begin
      check(got_off[i] == exp_off[i], tag, "offset", got_off[i], exp_off[i]);
      check(got_dat[i] == exp_dat[i], tag, "data", got_dat[i], exp_dat[i]);
      check(got_sel[i] == exp_sel[i], "R3", "select", got_sel[i], exp_sel[i]);
    end
    if (exp_err) begin
      repeat (3) @(negedge clk);
      check(!mem_req && !wr_stb && !busy && ngot == nexp, "R10", "activity after error",
            longint'({mem_req, wr_stb, busy}), 0);
    end
  endtask

  initial begin
    int n0;
    nchk = 0; nfail = 0; ngot = 0;
    clear_list();
    repeat (2) @(negedge clk);
    check({busy, done, err, mem_req, wr_stb} == 5'b0, "R1", "reset outputs",
          longint'({busy, done, err, mem_req, wr_stb}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, err, mem_req, wr_stb} == 5'b0, "R1", "idle outputs",
          longint'({busy, done, err, mem_req, wr_stb}), 0);

    // R2: empty list
    clear_list();
    run_list(0, 1'b0, "R2");

    // R3: every mask bit alone, then all bits set
    for (int i = 0; i < 32; i++) begin
      clear_list();
      add_sel(32'h1 << i);
      add_single(32'h40, pay(i));
      run_list(wp, 1'b0, "R3");
    end
    clear_list();
    add_sel(32'hFFFF_FFFF);
    add_single(32'h44, 32'h1234_5678);
    run_list(wp, 1'b0, "R3");

    // R7: all legal wrap lengths, payload longer than the window
    for (int w = 2; w < 16; w++) begin
      clear_list();
      add_sel(32'h0002_0001);
      add_block(32'h200, 1'b0, w, 20);
      run_list(wp, 1'b0, "R7");
    end
    clear_list();
    add_sel(32'h0000_0010);
    add_block(32'h300, 1'b1, 5, 6);
    add_block(32'h400, 1'b1, 0, 3);
    run_list(wp, 1'b0, "R7");

    // R4 R5 R6 R8 mixed stream, including offset roll-over
    clear_list();
    add_sel(32'h0020_0000);
    add_single(32'h10, 32'hCAFE_0001);
    add_auto(32'h80, 6);
    add_index(32'hFFFFC, 4);
    add_auto(32'h90, 0);
    add_index(32'h4, 0);
    add_block(32'h0, 1'b0, 3, 0);
    add_auto(32'hFFFF8, 4);
    add_single(32'h20, 32'hCAFE_0002);
    run_list(wp, 1'b0, "R4,R5,R6,R8");

    // R8 alone
    clear_list();
    add_sel(32'h0000_0001);
    add_auto(32'h100, 0);
    run_list(wp, 1'b0, "R8");

    // R10: unknown opcodes
    for (int op = 0; op < 8; op++) begin
      if (op == 1 || op == 3 || op == 4 || op == 5) continue;
      clear_list();
      add_sel(32'h0000_0002);
      add_single(32'h8, 32'h0BAD_0000 + 32'(op));
      put({1'b0, op[2:0], 28'h0000_100});
      n0 = nexp;
      add_single(32'hC, 32'h0);
      nexp = n0;
      run_list(wp, 1'b1, "R10");
    end

    // R11: write without select, and a second select
    clear_list();
    add_single(32'h8, 32'h1);
    nexp = 0;
    run_list(wp, 1'b1, "R11");
    clear_list();
    add_sel(32'h0000_0004);
    add_single(32'h8, 32'h2);
    n0 = nexp;
    add_sel(32'h0000_0008);
    add_single(32'hC, 32'h3);
    nexp = n0;
    run_list(wp, 1'b1, "R11");

    // R12: short wrap and misaligned offset
    for (int w = 0; w < 2; w++) begin
      clear_list();
      add_sel(32'h0000_0001);
      n0 = nexp;
      add_block(32'h100, 1'b0, w, 4);
      nexp = n0;
      run_list(wp, 1'b1, "R12");
    end
    clear_list();
    add_sel(32'h0000_0001);
    add_single(32'h4, 32'h7);
    put(32'h1000_0102);
    put(32'h8);
    run_list(wp, 1'b1, "R12");

    // R13: budget ends inside a payload
    clear_list();
    add_sel(32'h0000_0001);
    add_auto(32'h40, 5);
    nexp = 2;
    run_list(wp - 3, 1'b1, "R13");
    // R13: budget ends inside a select command
    clear_list();
    add_sel(32'h0000_0001);
    run_list(1, 1'b1, "R13");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end
endmodule